// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a half-duplex serial slave that lets a host read and write a small set of configuration registers over a four-signal serial link (select, clock, data in, data out). The link runs without any relation to the block's own clock: select, serial clock and serial data are brought into the system clock domain through synchronizers. Edges of the serial clock are detected there. Data is sampled on rising serial clock edges, and read data changes after falling edges.

Each transaction begins with a 16-bit instruction. The instruction holds a read flag, a two-bit byte count equal to the number of data bytes minus one, and a 13-bit register address. Between one and four data bytes follow, and the address moves up by one for each byte. A configuration register selects the bit order (most significant first or least significant first), chooses shared-pin or separate-pin read data, and triggers a soft reset. The other registers are read-only identity bytes, a converter select, a clock-divide select and an output-format select. Each of the writable fields drives a port of the block. The select, divide and format fields ignore writes of codes that are not valid for them.

Top module: `spi_cfg_slave`

## Requirements
- R1: In most-significant-first order the instruction is sent as read flag (1 = read), count bit 1, count bit 0, then address bit 12 down to bit 0, and each data byte follows from bit 7 down to bit 0. Bits are sampled on rising serial clock edges.
- R2: Setting bit 0 of register 0x00 selects least-significant-first order: address bit 0 up to bit 12, count bit 0, count bit 1, the read flag, and then each data byte from bit 0 up to bit 7. The order is captured while select is high, so a change applies from the next transaction.
- R3: The count field gives the number of data bytes minus one (1 to 4 bytes), and the address steps by one for each byte. Clocks after the last counted byte are ignored.
- R4: Address 0x08 reads the chip identifier (default 0xA5) and address 0x09 reads the revision (default 0x02). Writes to either address have no effect.
- R5: Bits 1:0 of 0x10 drive adc_sel. The reset value is 01. A write of 01 or 10 is taken, a write of 00 or 11 is ignored, and the upper bits read 0.
- R6: Bits 2:0 of 0x73 drive out_mode. The codes are 000 pin control, 001 differential low drive, 010 differential high drive and 100 single-ended. The reset value is 000, and writes of any other code are ignored.
- R7: Bits 1:0 of 0x72 drive clk_div. The codes are 00 pin control, 01 divide by one and 10 divide by two. The reset value is 00, and a write of 11 is ignored.
- R8: Writing 1 to bit 1 of 0x00 returns every register to its reset value two clock cycles after the write is taken. The bit then reads 0.
- R9: When bit 2 of 0x00 is 0, read data leaves on spi_sdio_out with spi_sdio_oe high and spi_sdo_oe low. When bit 2 is 1, read data leaves on spi_sdo with spi_sdo_oe high and spi_sdio_oe low.
- R10: While spi_csn is high, both output enables are low and the bit counters restart, so an aborted transaction leaves no trace.
- R11: Unmapped addresses read as 0x00, and writes to them are ignored.
- R12: The synchronous active-high rst puts every register and output into its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, asynchronous to clk |
| spi_csn | input | 1 | Active-low transaction select |
| spi_sdio_in | input | 1 | Serial data from the host |
| spi_sdio_out | output | 1 | Read data for the shared data pin |
| spi_sdio_oe | output | 1 | Driver enable for the shared data pin |
| spi_sdo | output | 1 | Read data for the separate output pin |
| spi_sdo_oe | output | 1 | Driver enable for the separate output pin |
| adc_sel | output | 2 | Converter select field |
| out_mode | output | 3 | Output format field |
| clk_div | output | 2 | Clock divide field |

## Verification
Read data changes three clock cycles after a falling serial clock edge: two synchronizer stages plus the output register. The bench holds each serial clock phase for eight clock cycles and samples read data just before it raises the serial clock. That leaves five cycles of margin. A register write is taken three cycles after the rising edge of its last data bit, and a soft reset lands two cycles after that. The bench therefore checks adc_sel, out_mode and clk_div only after raising select and waiting a further sixteen cycles.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 13;
  localparam int BYTE_W = 8;
  localparam int INSTR_W = 3 + ADDR_W;
  localparam int ICNT_W = $clog2(INSTR_W);
  localparam int DCNT_W = $clog2(BYTE_W);

  localparam logic [ADDR_W-1:0] A_CFG   = 13'h000;
  localparam logic [ADDR_W-1:0] A_ID    = 13'h008;
  localparam logic [ADDR_W-1:0] A_REV   = 13'h009;
  localparam logic [ADDR_W-1:0] A_INDEX = 13'h010;
  localparam logic [ADDR_W-1:0] A_CDIV  = 13'h072;
  localparam logic [ADDR_W-1:0] A_OMODE = 13'h073;

  localparam int CFG_LSB  = 0;
  localparam int CFG_SOFT = 1;
  localparam int CFG_FOUR = 2;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;

  function automatic logic omode_ok(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b001) || (c == 3'b010) || (c == 3'b100);
  endfunction

  function automatic logic idx_ok(input logic [1:0] c);
    return (c == 2'b01) || (c == 2'b10);
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain <= d[b];
      else chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_cfg_serial.sv
module spi_cfg_serial
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic              lsb_cfg,
  input  logic              four_cfg,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              tx_bit,
  output logic              sdio_oe,
  output logic              sdo_oe
);
  logic               sclk_d, rise, fall, lsb_q, is_rd;
  phase_t             phase;
  logic [ICNT_W-1:0]  icnt;
  logic [DCNT_W-1:0]  dcnt;
  logic [1:0]         left;
  logic [INSTR_W-1:0] instr, instr_nx;
  logic [BYTE_W-1:0]  rx, rx_nx, tx_sh, tx_src;
  logic [ADDR_W-1:0]  addr;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;
  assign rd_addr = addr;

  always_comb begin
    instr_nx = lsb_q ? {mosi_s, instr[INSTR_W-1:1]} : {instr[INSTR_W-2:0], mosi_s};
    rx_nx    = lsb_q ? {mosi_s, rx[BYTE_W-1:1]} : {rx[BYTE_W-2:0], mosi_s};
    tx_src   = (dcnt == '0) ? rd_data : tx_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      phase <= PH_INSTR;
      icnt <= '0;
      dcnt <= '0;
      left <= '0;
      lsb_q <= 1'b0;
      is_rd <= 1'b0;
      instr <= '0;
      rx <= '0;
      tx_sh <= '0;
      addr <= '0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      tx_bit <= 1'b0;
      sdio_oe <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      wr_en <= 1'b0;
      if (csn_s) begin
        phase <= PH_INSTR;
        icnt <= '0;
        dcnt <= '0;
        lsb_q <= lsb_cfg;
        sdio_oe <= 1'b0;
        sdo_oe <= 1'b0;
      end else begin
        if (rise) begin
          unique case (phase)
            PH_INSTR: begin
              instr <= instr_nx;
              icnt <= icnt + 1'b1;
              if (icnt == ICNT_W'(INSTR_W - 1)) begin
                addr <= instr_nx[ADDR_W-1:0];
                left <= instr_nx[ADDR_W+1:ADDR_W];
                is_rd <= instr_nx[INSTR_W-1];
                dcnt <= '0;
                phase <= PH_DATA;
              end
            end
            PH_DATA: begin
              rx <= rx_nx;
              dcnt <= dcnt + 1'b1;
              if (dcnt == DCNT_W'(BYTE_W - 1)) begin
                if (!is_rd) begin
                  wr_en <= 1'b1;
                  wr_addr <= addr;
                  wr_data <= rx_nx;
                end
                addr <= addr + 1'b1;
                if (left == 2'd0) phase <= PH_DONE;
                else left <= left - 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (fall) begin
          if (phase == PH_DATA && is_rd) begin
            sdio_oe <= ~four_cfg;
            sdo_oe <= four_cfg;
            tx_bit <= lsb_q ? tx_src[0] : tx_src[BYTE_W-1];
            tx_sh <= lsb_q ? (tx_src >> 1) : (tx_src << 1);
          end else if (phase == PH_DONE) begin
            sdio_oe <= 1'b0;
            sdo_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'hA5,
  parameter logic [BYTE_W-1:0] CHIP_REV = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              lsb_first,
  output logic              four_wire,
  output logic [1:0]        adc_sel,
  output logic [2:0]        out_mode,
  output logic [1:0]        clk_div
);
  logic soft_pend;

  always_ff @(posedge clk) begin
    if (rst || soft_pend) begin
      soft_pend <= 1'b0;
      lsb_first <= 1'b0;
      four_wire <= 1'b0;
      adc_sel <= 2'b01;
      out_mode <= 3'b000;
      clk_div <= 2'b00;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CFG: begin
          lsb_first <= wr_data[CFG_LSB];
          four_wire <= wr_data[CFG_FOUR];
          soft_pend <= wr_data[CFG_SOFT];
        end
        A_INDEX: if (idx_ok(wr_data[1:0])) adc_sel <= wr_data[1:0];
        A_CDIV:  if (wr_data[1:0] != 2'b11) clk_div <= wr_data[1:0];
        A_OMODE: if (omode_ok(wr_data[2:0])) out_mode <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CFG: begin
        rd_data[CFG_LSB] = lsb_first;
        rd_data[CFG_FOUR] = four_wire;
      end
      A_ID:    rd_data = CHIP_ID;
      A_REV:   rd_data = CHIP_REV;
      A_INDEX: rd_data[1:0] = adc_sel;
      A_CDIV:  rd_data[1:0] = clk_div;
      A_OMODE: rd_data[2:0] = out_mode;
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CHIP_ID = 8'hA5,
  parameter logic [7:0] CHIP_REV = 8'h02
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sclk,
  input  logic       spi_csn,
  input  logic       spi_sdio_in,
  output logic       spi_sdio_out,
  output logic       spi_sdio_oe,
  output logic       spi_sdo,
  output logic       spi_sdo_oe,
  output logic [1:0] adc_sel,
  output logic [2:0] out_mode,
  output logic [1:0] clk_div
);
  logic [2:0]        pins_s;
  logic              lsb_first, four_wire, wr_en, tx_bit;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  spi_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sdio_in, spi_csn, spi_sclk}),
    .q(pins_s)
  );

  spi_cfg_serial u_serial (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[0]), .csn_s(pins_s[1]), .mosi_s(pins_s[2]),
    .lsb_cfg(lsb_first), .four_cfg(four_wire),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_bit(tx_bit), .sdio_oe(spi_sdio_oe), .sdo_oe(spi_sdo_oe)
  );

  spi_cfg_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .lsb_first(lsb_first), .four_wire(four_wire),
    .adc_sel(adc_sel), .out_mode(out_mode), .clk_div(clk_div)
  );

  assign spi_sdio_out = tx_bit;
  assign spi_sdo = tx_bit;
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
  import spi_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              spi_csn,
  input logic              spi_sdio_oe,
  input logic              spi_sdo_oe,
  input logic [1:0]        adc_sel,
  input logic [2:0]        out_mode,
  input logic [1:0]        clk_div,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data
);
  // R9
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(spi_sdio_oe && spi_sdo_oe));

  // R10
  csn_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3) && $past(spi_csn, 4))
    |-> (!spi_sdio_oe && !spi_sdo_oe));

  // R5
  adc_sel_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(adc_sel) == 1);

  // R6
  out_mode_code_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_mode));

  // R6
  out_mode_reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_OMODE && !$onehot0(wr_data[2:0])) |=> $stable(out_mode));

  // R7
  clk_div_valid_chk: assert property (@(posedge clk) disable iff (rst)
    clk_div != 2'b11);

  // R8
  soft_reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CFG && wr_data[CFG_SOFT])
    |-> ##2 (out_mode == 3'b000 && clk_div == 2'b00 && adc_sel == 2'b01));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk u_chk (.*);

// File: tb/spi_cfg_slave_test.sv
`timescale 1ns/1ps
module spi_cfg_slave_test;
  localparam int HALF = 8;
  localparam logic [7:0] EXP_ID = 8'hA5;
  localparam logic [7:0] EXP_REV = 8'h02;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic sdio_out, sdio_oe, sdo, sdo_oe;
  logic [1:0] adc_sel, clk_div;
  logic [2:0] out_mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_cfg_slave uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_sdio_in(mosi),
    .spi_sdio_out(sdio_out), .spi_sdio_oe(sdio_oe), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
    .adc_sel(adc_sel), .out_mode(out_mode), .clk_div(clk_div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  // Host transaction: nb counted bytes, extra clocked bytes beyond the count.
  task automatic xfer(input bit lsb, input bit rd, input int nb, input int extra,
                      input logic [12:0] a, input logic [31:0] wd, input bit four,
                      output logic [31:0] rdo, output bit oe_bad);
    logic [15:0] w;
    logic [1:0] cnt;
    cnt = 2'(nb - 1);
    w = {rd, cnt, a};
    rdo = '0;
    oe_bad = 0;
    @(negedge clk);
    csn = 1'b0;
    half();
    for (int i = 0; i < 16; i++) begin
      mosi = lsb ? w[i] : w[15 - i];
      half();
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
    for (int b = 0; b < nb + extra; b++) begin
      for (int k = 0; k < 8; k++) begin
        int pos;
        pos = lsb ? k : 7 - k;
        mosi = wd[8*b + pos];
        half();
        if (rd && b < nb) begin
          rdo[8*b + pos] = four ? sdo : sdio_out;
          if (sdio_oe !== !four || sdo_oe !== four) oe_bad = 1;
        end
        sclk = 1'b1;
        half();
        sclk = 1'b0;
      end
    end
    half();
    csn = 1'b1;
    half();
    half();
  endtask

  task automatic wr1(input bit lsb, input logic [12:0] a, input logic [7:0] d);
    logic [31:0] r; bit o;
    xfer(lsb, 1'b0, 1, 0, a, {24'h0, d}, 1'b0, r, o);
  endtask

  task automatic rd1(input bit lsb, input logic [12:0] a, output logic [7:0] d);
    logic [31:0] r; bit o;
    xfer(lsb, 1'b1, 1, 0, a, 32'h0, 1'b0, r, o);
    d = r[7:0];
    chk("R9 shared-pin enables during read", {31'h0, o}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R12 adc_sel after reset", adc_sel, 2'b01);
    chk("R12 out_mode after reset", out_mode, 3'b000);
    chk("R12 clk_div after reset", clk_div, 2'b00);
    chk("R10 enables idle", {sdio_oe, sdo_oe}, 2'b00);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    rd1(0, 13'h008, d); chk("R1 R4 chip id read", d, EXP_ID);
    rd1(0, 13'h009, d); chk("R4 revision read", d, EXP_REV);
    wr1(0, 13'h008, 8'h3C);
    rd1(0, 13'h008, d); chk("R4 id write ignored", d, EXP_ID);
  endtask

  task automatic t_burst();
    logic [31:0] r; bit o;
    xfer(0, 1'b0, 2, 0, 13'h072, 32'h0000_0102, 1'b0, r, o);
    chk("R3 R7 burst byte0 to clk_div", clk_div, 2'b10);
    chk("R3 R6 burst byte1 to out_mode", out_mode, 3'b001);
    xfer(0, 1'b1, 2, 0, 13'h072, 32'h0, 1'b0, r, o);
    chk("R3 two-byte read", r, 32'h0000_0102);
  endtask

  task automatic t_reserved();
    wr1(0, 13'h073, 8'h03); chk("R6 reserved mode 011 ignored", out_mode, 3'b001);
    wr1(0, 13'h073, 8'h06); chk("R6 reserved mode 110 ignored", out_mode, 3'b001);
    wr1(0, 13'h072, 8'h03); chk("R7 divide code 11 ignored", clk_div, 2'b10);
    wr1(0, 13'h073, 8'h04); chk("R6 single-ended code taken", out_mode, 3'b100);
  endtask

  task automatic t_index();
    logic [7:0] d;
    wr1(0, 13'h010, 8'h00); chk("R5 select 00 ignored", adc_sel, 2'b01);
    wr1(0, 13'h010, 8'hFE); chk("R5 select 10 taken", adc_sel, 2'b10);
    wr1(0, 13'h010, 8'h03); chk("R5 select 11 ignored", adc_sel, 2'b10);
    rd1(0, 13'h010, d); chk("R5 select readback", d, 8'h02);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr1(0, 13'h1ABC, 8'hFF);
    rd1(0, 13'h1ABC, d); chk("R11 unmapped reads zero", d, 8'h00);
    chk("R11 unmapped write no port change", {adc_sel, out_mode, clk_div}, {2'b10, 3'b100, 2'b10});
  endtask

  task automatic t_extra();
    logic [31:0] r; bit o;
    xfer(0, 1'b0, 1, 1, 13'h072, 32'h0000_0101, 1'b0, r, o);
    chk("R3 counted byte written", clk_div, 2'b01);
    chk("R3 byte beyond count ignored", out_mode, 3'b100);
  endtask

  task automatic t_four();
    logic [31:0] r; bit o;
    wr1(0, 13'h000, 8'h04);
    xfer(0, 1'b1, 1, 0, 13'h009, 32'h0, 1'b1, r, o);
    chk("R9 separate-pin read data", r, {24'h0, EXP_REV});
    chk("R9 separate-pin enables", {31'h0, o}, 32'h0);
    wr1(0, 13'h000, 8'h00);
  endtask

  task automatic t_lsb();
    logic [7:0] d;
    wr1(0, 13'h000, 8'h01);
    rd1(1, 13'h008, d); chk("R2 lsb-first id read", d, EXP_ID);
    wr1(1, 13'h073, 8'h01); chk("R2 lsb-first write", out_mode, 3'b001);
    rd1(1, 13'h000, d); chk("R2 config readback", d, 8'h01);
  endtask

  task automatic t_soft();
    logic [7:0] d;
    wr1(1, 13'h000, 8'h02);
    chk("R8 out_mode default", out_mode, 3'b000);
    chk("R8 clk_div default", clk_div, 2'b00);
    chk("R8 adc_sel default", adc_sel, 2'b01);
    rd1(0, 13'h000, d); chk("R8 config cleared, msb order back", d, 8'h00);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    @(negedge clk);
    csn = 1'b0;
    half();
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; half(); sclk = 1'b1; half(); sclk = 1'b0;
    end
    half();
    csn = 1'b1;
    half(); half();
    chk("R10 enables low after abort", {sdio_oe, sdo_oe}, 2'b00);
    rd1(0, 13'h008, d); chk("R10 counter restart", d, EXP_ID);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_ident();
    t_burst();
    t_reserved();
    t_index();
    t_unmapped();
    t_extra();
    t_four();
    t_lsb();
    t_soft();
    t_abort();
    finish_run();
  end
endmodule